// File: doc/BRIEF.md
# Inbound Memory Address Translator

This block sits behind the target side of a PCI interface and turns the address of an inbound memory transaction into a 32-bit local address. It holds six target windows. Each window has a PCI-side base, a size mask, a local translation base and an enable bit. All of them are loaded through a single write port: a window index, a field code and a 32-bit data word. A window matches an address when the address bits selected by its mask equal the same bits of its base. The local address takes its masked upper bits from the translation base and its remaining low bits from the incoming address.

Each lookup gives one of three outcomes. On a hit, the block produces an address and the index of the matching window. On an abort, the matching window is switched off, so the transaction must be target-aborted. On a miss, no window matches and the transaction is not claimed. When windows overlap, the highest-numbered matching window decides the outcome, even if that window is disabled. A hit whose translated address lands inside the outbound initiator region, which is set by two parameters, also raises an error flag. A controller would otherwise loop such a transaction back onto the bus. All results are registered and appear one cycle after the request.

Top module: `pci_inxlat`

## Requirements
- R1: After reset every window enable is clear and every window register is zero. So the first lookup after reset matches all windows and reports an abort on window 5.
- R2: Window i matches when `((addr ^ base_i) & mask_i) == 0`. A mask bit of 1 means the bit is compared.
- R3: On a hit, `xaddr = (xbase & mask) | (addr & ~mask)`, using the selected window's registers.
- R4: If the selected window's enable bit is 0, the result is abort. `xaddr` is 0 and `win` holds that window's index.
- R5: If no window matches, the result is no-hit, with `xaddr` = 0 and `win` = 0.
- R6: When several windows match, the highest-numbered one is selected, whether it is enabled or not.
- R7: `ini_err` is 1 only on a hit whose `xaddr` satisfies `((xaddr ^ INI_BASE) & INI_MASK) == 0`. The defaults are `INI_BASE` = 0xC000_0000 and `INI_MASK` = 0xC000_0000.
- R8: `out_valid` follows `in_valid` by exactly one clock. While `out_valid` is 0, all flags, `win` and `xaddr` are 0.
- R9: Field codes on `cfg_field` are: 0 = PCI base, 1 = mask, 2 = translation base, 3 = enable (data bit 0). A write takes effect for lookups in the following cycle. Writes with `cfg_win` of 6 or 7 change no window.
- R10: Whenever `out_valid` is 1, exactly one of `hit`, `abort` and `nohit` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Window register write strobe |
| cfg_win | input | 3 | Window index for the write |
| cfg_field | input | 2 | Field code for the write |
| cfg_wdata | input | 32 | Write data |
| in_valid | input | 1 | Lookup request |
| in_addr | input | 32 | Inbound PCI memory address |
| out_valid | output | 1 | Result valid |
| out_hit | output | 1 | Enabled window hit, address valid |
| out_abort | output | 1 | Selected window disabled |
| out_nohit | output | 1 | No window matched |
| out_win | output | 3 | Selected window index |
| out_xaddr | output | 32 | Translated local address |
| out_ini_err | output | 1 | Translation lands in initiator space |

## Verification
Every lookup result appears exactly one clock after the request. The bench drives each request on a falling edge, so the rising edge in between captures it. It then reads all outputs on the next falling edge, one full period after the request. A register write also needs one rising edge before it affects a lookup. Each directed test therefore issues its write, waits for that edge, and only then sends its request, so a stale value is never sampled.

// File: rtl/inxlat_pkg.sv
package inxlat_pkg;
  typedef enum logic [1:0] {
    FLD_PCI_BASE = 2'd0,
    FLD_MASK     = 2'd1,
    FLD_XBASE    = 2'd2,
    FLD_ENABLE   = 2'd3
  } win_field_e;
endpackage

// File: rtl/inxlat_regs.sv
module inxlat_regs #(
  parameter int AW     = 32,
  parameter int NWIN   = 6,
  parameter int WIDX_W = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cfg_we,
  input  logic [WIDX_W-1:0]        cfg_win,
  input  logic [1:0]               cfg_field,
  input  logic [AW-1:0]            cfg_wdata,
  output logic [NWIN-1:0][AW-1:0]  base_q,
  output logic [NWIN-1:0][AW-1:0]  mask_q,
  output logic [NWIN-1:0][AW-1:0]  xbase_q,
  output logic [NWIN-1:0]          en_q
);
  import inxlat_pkg::*;

  win_field_e fld;
  assign fld = win_field_e'(cfg_field);

  for (genvar i = 0; i < NWIN; i++) begin : g_win
    logic sel;
    assign sel = cfg_we && (cfg_win == WIDX_W'(i));
    always_ff @(posedge clk) begin
      if (rst) begin
        base_q[i]  <= '0;
        mask_q[i]  <= '0;
        xbase_q[i] <= '0;
        en_q[i]    <= 1'b0;
      end else if (sel) begin
        case (fld)
          FLD_PCI_BASE: base_q[i]  <= cfg_wdata;
          FLD_MASK:     mask_q[i]  <= cfg_wdata;
          FLD_XBASE:    xbase_q[i] <= cfg_wdata;
          FLD_ENABLE:   en_q[i]    <= cfg_wdata[0];
          default:      ;
        endcase
      end
    end
  end

  // R1: enables come out of reset cleared
  a_r1_en_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (en_q == '0));

  // R9: an out-of-range index leaves every window untouched
  a_r9_bad_index_ignored: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && (32'(cfg_win) >= NWIN)) |=> ($stable(en_q) && $stable(base_q)
                                           && $stable(mask_q) && $stable(xbase_q)));
endmodule

// File: rtl/inxlat_match.sv
module inxlat_match #(
  parameter int AW   = 32,
  parameter int NWIN = 6
) (
  input  logic [AW-1:0]            addr,
  input  logic [NWIN-1:0][AW-1:0]  base_q,
  input  logic [NWIN-1:0][AW-1:0]  mask_q,
  output logic [NWIN-1:0]          hit_vec
);
  for (genvar i = 0; i < NWIN; i++) begin : g_cmp
    assign hit_vec[i] = ((addr ^ base_q[i]) & mask_q[i]) == '0;
  end
endmodule

// File: rtl/inxlat_prio.sv
module inxlat_prio #(
  parameter int NWIN   = 6,
  parameter int WIDX_W = 3
) (
  input  logic [NWIN-1:0]    hit_vec,
  output logic               any_hit,
  output logic [WIDX_W-1:0]  sel_idx
);
  always_comb begin
    any_hit = 1'b0;
    sel_idx = '0;
    for (int i = 0; i < NWIN; i++) begin
      if (hit_vec[i]) begin
        any_hit = 1'b1;
        sel_idx = WIDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/pci_inxlat.sv
module pci_inxlat #(
  parameter int              AW       = 32,
  parameter int              NWIN     = 6,
  parameter logic [AW-1:0]   INI_BASE = 32'hC000_0000,
  parameter logic [AW-1:0]   INI_MASK = 32'hC000_0000,
  localparam int             WIDX_W   = $clog2(NWIN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [WIDX_W-1:0] cfg_win,
  input  logic [1:0]        cfg_field,
  input  logic [AW-1:0]     cfg_wdata,
  input  logic              in_valid,
  input  logic [AW-1:0]     in_addr,
  output logic              out_valid,
  output logic              out_hit,
  output logic              out_abort,
  output logic              out_nohit,
  output logic [WIDX_W-1:0] out_win,
  output logic [AW-1:0]     out_xaddr,
  output logic              out_ini_err
);
  logic [NWIN-1:0][AW-1:0] base_q, mask_q, xbase_q;
  logic [NWIN-1:0]         en_q;
  logic [NWIN-1:0]         hit_vec;
  logic                    any_hit;
  logic [WIDX_W-1:0]       sel_idx;

  inxlat_regs #(.AW(AW), .NWIN(NWIN), .WIDX_W(WIDX_W)) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_win(cfg_win),
    .cfg_field(cfg_field), .cfg_wdata(cfg_wdata),
    .base_q(base_q), .mask_q(mask_q), .xbase_q(xbase_q), .en_q(en_q)
  );

  inxlat_match #(.AW(AW), .NWIN(NWIN)) u_match (
    .addr(in_addr), .base_q(base_q), .mask_q(mask_q), .hit_vec(hit_vec)
  );

  inxlat_prio #(.NWIN(NWIN), .WIDX_W(WIDX_W)) u_prio (
    .hit_vec(hit_vec), .any_hit(any_hit), .sel_idx(sel_idx)
  );

  logic [AW-1:0] sel_mask, sel_xbase, xaddr_d;
  logic          sel_en, good_d, ini_d;

  always_comb begin
    sel_mask  = mask_q[sel_idx];
    sel_xbase = xbase_q[sel_idx];
    sel_en    = en_q[sel_idx];
    xaddr_d   = (sel_xbase & sel_mask) | (in_addr & ~sel_mask);
    good_d    = any_hit && sel_en;
    ini_d     = ((xaddr_d ^ INI_BASE) & INI_MASK) == '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_hit     <= 1'b0;
      out_abort   <= 1'b0;
      out_nohit   <= 1'b0;
      out_win     <= '0;
      out_xaddr   <= '0;
      out_ini_err <= 1'b0;
    end else begin
      out_valid   <= in_valid;
      out_hit     <= in_valid && good_d;
      out_abort   <= in_valid && any_hit && !sel_en;
      out_nohit   <= in_valid && !any_hit;
      out_win     <= (in_valid && any_hit) ? sel_idx : '0;
      out_xaddr   <= (in_valid && good_d) ? xaddr_d : '0;
      out_ini_err <= in_valid && good_d && ini_d;
    end
  end

  // R8: one-cycle latency
  a_r8_latency: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (out_valid == $past(in_valid)));

  // R8: quiet outputs when no result
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (!out_hit && !out_abort && !out_nohit && !out_ini_err
                    && out_xaddr == '0 && out_win == '0));

  // R10: exactly one outcome
  a_r10_one_outcome: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($countones({out_hit, out_abort, out_nohit}) == 1));

  // R7: error only accompanies a hit
  a_r7_err_needs_hit: assert property (@(posedge clk) disable iff (rst)
    out_ini_err |-> out_hit);

  // R5 / R4: no address on miss or abort
  a_r5_miss_no_addr: assert property (@(posedge clk) disable iff (rst)
    (out_nohit || out_abort) |-> (out_xaddr == '0));
endmodule

// File: tb/pci_inxlat_tb.sv
module pci_inxlat_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 9;

  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_we;
  logic [2:0]  cfg_win;
  logic [1:0]  cfg_field;
  logic [31:0] cfg_wdata;
  logic        in_valid;
  logic [31:0] in_addr;
  logic        out_valid, out_hit, out_abort, out_nohit, out_ini_err;
  logic [2:0]  out_win;
  logic [31:0] out_xaddr;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pci_inxlat u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_win(cfg_win),
    .cfg_field(cfg_field), .cfg_wdata(cfg_wdata), .in_valid(in_valid),
    .in_addr(in_addr), .out_valid(out_valid), .out_hit(out_hit),
    .out_abort(out_abort), .out_nohit(out_nohit), .out_win(out_win),
    .out_xaddr(out_xaddr), .out_ini_err(out_ini_err)
  );

  // outcome codes: 1 hit, 2 abort, 3 no-hit
  localparam logic [31:0] V_ADDR  [NV] = '{32'h1012_3456, 32'h10FF_FFFF, 32'h1080_1234,
                                          32'h2ABC_DEF0, 32'h3001_0000, 32'h6001_0000,
                                          32'h6050_0000, 32'h9000_0000, 32'h0FFF_FFFF};
  localparam logic [1:0]  V_KIND  [NV] = '{2'd1, 2'd1, 2'd1, 2'd1, 2'd2, 2'd2, 2'd1, 2'd3, 2'd3};
  localparam logic [2:0]  V_WIN   [NV] = '{3'd0, 3'd0, 3'd3, 3'd1, 3'd2, 3'd5, 3'd4, 3'd0, 3'd0};
  localparam logic [31:0] V_XADDR [NV] = '{32'h4012_3456, 32'h40FF_FFFF, 32'h5500_1234,
                                          32'hCABC_DEF0, 32'h0, 32'h0,
                                          32'h7050_0000, 32'h0, 32'h0};
  localparam logic        V_ERR   [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0};
  localparam string       V_REQ   [NV] = '{"R3", "R2", "R6", "R7", "R4", "R6", "R3", "R5", "R2"};

  function automatic logic [1:0] kind_of();
    if (out_hit) return 2'd1;
    if (out_abort) return 2'd2;
    if (out_nohit) return 2'd3;
    return 2'd0;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] w, input logic [1:0] f, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_win = w; cfg_field = f; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // request on a falling edge, result read one period later
  task automatic lookup(input logic [31:0] a);
    @(negedge clk);
    in_valid = 1'b1; in_addr = a;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic chk_result(input string req, input logic [1:0] k, input logic [2:0] w,
                            input logic [31:0] xa, input logic e);
    chk(out_valid == 1'b1, req, {31'b0, out_valid}, 32'd1);
    chk(kind_of() == k, req, {30'b0, kind_of()}, {30'b0, k});
    chk(out_win == w, req, {29'b0, out_win}, {29'b0, w});
    chk(out_xaddr == xa, req, out_xaddr, xa);
    chk(out_ini_err == e, req, {31'b0, out_ini_err}, {31'b0, e});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; cfg_we = 1'b0; cfg_win = '0; cfg_field = '0; cfg_wdata = '0;
    in_valid = 1'b0; in_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 / R8: idle outputs after reset
    chk(out_valid == 1'b0 && kind_of() == 2'd0 && out_xaddr == '0, "R8",
        {31'b0, out_valid}, 32'd0);
    // R1: all-zero windows match everything, window 5 selected and disabled
    lookup(32'h1234_5678);
    chk_result("R1", 2'd2, 3'd5, 32'h0, 1'b0);

    wr(3'd0, 2'd0, 32'h1000_0000); wr(3'd0, 2'd1, 32'hFF00_0000);
    wr(3'd0, 2'd2, 32'h4000_0000); wr(3'd0, 2'd3, 32'h1);
    wr(3'd1, 2'd0, 32'h2000_0000); wr(3'd1, 2'd1, 32'hF000_0000);
    wr(3'd1, 2'd2, 32'hC100_0000); wr(3'd1, 2'd3, 32'h1);
    wr(3'd2, 2'd0, 32'h3000_0000); wr(3'd2, 2'd1, 32'hFFF0_0000);
    wr(3'd2, 2'd2, 32'h0800_0000);
    wr(3'd3, 2'd0, 32'h1080_0000); wr(3'd3, 2'd1, 32'hFFF0_0000);
    wr(3'd3, 2'd2, 32'h5500_0000); wr(3'd3, 2'd3, 32'h1);
    wr(3'd4, 2'd0, 32'h6000_0000); wr(3'd4, 2'd1, 32'hFF00_0000);
    wr(3'd4, 2'd2, 32'h7000_0000); wr(3'd4, 2'd3, 32'h1);
    wr(3'd5, 2'd0, 32'h6000_0000); wr(3'd5, 2'd1, 32'hFFF0_0000);
    wr(3'd5, 2'd2, 32'h0A00_0000);

    for (int i = 0; i < NV; i++) begin
      lookup(V_ADDR[i]);
      chk_result(V_REQ[i], V_KIND[i], V_WIN[i], V_XADDR[i], V_ERR[i]);
    end

    // R8: no request -> out_valid low and outputs quiet
    @(negedge clk);
    chk(out_valid == 1'b0 && out_xaddr == '0 && kind_of() == 2'd0, "R8",
        {31'b0, out_valid}, 32'd0);

    // R9: enable window 2, takes effect for the next lookup
    wr(3'd2, 2'd3, 32'h1);
    lookup(32'h3001_0000);
    chk_result("R9", 2'd1, 3'd2, 32'h0801_0000, 1'b0);

    // R9: writes to indices 6 and 7 change nothing
    wr(3'd6, 2'd0, 32'h9000_0000); wr(3'd6, 2'd1, 32'hFF00_0000);
    wr(3'd7, 2'd1, 32'h0000_0000); wr(3'd7, 2'd3, 32'h0);
    lookup(32'h9000_0000);
    chk_result("R9", 2'd3, 3'd0, 32'h0, 1'b0);
    lookup(32'h1012_3456);
    chk_result("R9", 2'd1, 3'd0, 32'h4012_3456, 1'b0);

    // R6: disable window 3, overlap with window 0 now aborts on window 3
    wr(3'd3, 2'd3, 32'h0);
    lookup(32'h1080_1234);
    chk_result("R6", 2'd2, 3'd3, 32'h0, 1'b0);

    // R10: back-to-back requests, each result one cycle later
    @(negedge clk);
    in_valid = 1'b1; in_addr = 32'h6050_0000;
    @(negedge clk);
    chk_result("R10", 2'd1, 3'd4, 32'h7050_0000, 1'b0);
    in_addr = 32'h9000_0000;
    @(negedge clk);
    chk_result("R10", 2'd3, 3'd0, 32'h0, 1'b0);
    in_valid = 1'b0;

    // R1: reset clears enables again
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    lookup(32'h1012_3456);
    chk_result("R1", 2'd2, 3'd5, 32'h0, 1'b0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule